// File: doc/BRIEF.md
# Single-path pair predecoder with failure detection

This block is a low-cost first-pass decoder for a 64-state tail-biting convolutional code, arranged as a radix-4 trellis. It follows one path only and never updates path metrics. A start strobe gives it a starting state. Each accepted clock then delivers four branch metrics, one for each candidate bit pair. The block picks the smallest metric, emits that pair as two decoded bits, and shifts the pair into its current state. After 20 pairs, which make one 40-bit frame, it pulses `done`, presents the decoded word, and raises a fail flag when the word should not be trusted. When the flag is set, the full trellis decoder must take the frame.

Three independent checks feed the fail flag. The first is a tail-biting mismatch between the final state and the starting state. The second counts sections whose chosen metric is large. The third counts sections where the best and runner-up metrics lie close together. A parameter selects the direction of traversal. Two instances, one walking the frame forward and one walking it backward, therefore fail for different reasons on the same frame, and the second can be tried when the first fails.

Top module: `pair_predecoder`

## Requirements
- R1: After reset, `done`, `fail`, `fail_cause` and `word` are all zero.
- R2: In each accepted section the pair code with the smallest metric is chosen. Code c reads metric `metrics[c*7 +: 7]`, and bit 1 of the code is the earlier bit in time. On equal metrics the lower code wins.
- R3: The 40-bit `word` holds the chosen pairs in time order, with the earliest bit at bit 39. `done` is a one-cycle pulse in the cycle after the clock edge that accepts the 20th section.
- R4: `fail_cause[0]` is set when the final state (the last six decoded bits going forward, or the first six going backward, earliest bit most significant) differs from the loaded starting state.
- R5: `fail_cause[1]` is set when more than 4 sections have a chosen metric strictly greater than 20.
- R6: `fail_cause[2]` is set when more than 7 sections have a runner-up metric minus best metric strictly below 12. When the minimum is tied, the runner-up equals the best.
- R7: `fail` equals the OR of the three `fail_cause` bits. It is presented with `done` and held until the next frame ends.
- R8: `start` loads `start_state`, clears both counters and restarts the frame, even in the middle of a frame. A restarted frame produces exactly one `done`.
- R9: `in_valid` while no frame is active has no effect, and cycles with `in_valid` low inside a frame are skipped.
- R10: With `BACKWARD=1`, sections are presented last-first and the starting state is the frame's first six bits. The resulting `word` equals the forward result for the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame, load the starting state |
| start_state | input | 6 | Starting trellis state |
| in_valid | input | 1 | Metrics for one section are present |
| metrics | input | 28 | Four 7-bit branch metrics, code c at bits c*7 upward |
| done | output | 1 | One-cycle frame-complete pulse |
| fail | output | 1 | Frame needs the full decoder |
| fail_cause | output | 3 | Bit 0 tail mismatch, bit 1 high metrics, bit 2 narrow margins |
| word | output | 40 | Decoded frame, earliest bit at bit 39 |

## Verification
A forward and a backward instance receive the same frames, with each direction's sections in its own order. Clean frames, which give the true pair metric 0 and the other pairs 30, must pass and return the encoded word in both directions, with and without idle gaps. This separates correct pair ordering and shift direction from swapped bits or wrong stage order. A wrong starting state, high metrics at exactly the limit and one past it, and narrow margins at exactly the limit and one past it each trip their own cause bit alone. Tied metrics, a restart in mid-frame and idle-time valids show the tie rule, the counter clearing and the input gating.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef logic [1:0] pair_t;
    localparam int CAUSE_W   = 3;
    localparam int CAUSE_TAIL = 0;
    localparam int CAUSE_HIGH = 1;
    localparam int CAUSE_GAP  = 2;
endpackage

// File: rtl/pp_pick.sv
module pp_pick
    import pp_pkg::*;
#(
    parameter int MW = 7
) (
    input  logic [4*MW-1:0] metrics,
    output pair_t           code,
    output logic [MW-1:0]   best,
    output logic [MW-1:0]   second
);
    logic [MW-1:0] cand;

    always_comb begin
        best   = '1;
        second = '1;
        code   = '0;
        cand   = '0;
        for (int c = 0; c < 4; c++) begin
            cand = metrics[c*MW +: MW];
            if (cand < best) begin
                second = best;
                best   = cand;
                code   = pair_t'(c);
            end else if (cand < second) begin
                second = cand;
            end
        end
    end
endmodule

// File: rtl/pp_tally.sv
module pp_tally #(
    parameter int CW        = 5,
    parameter int HIT_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic over
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (bump) cnt_d = cnt_q + 1'b1;
        over = int'(cnt_d) > HIT_LIMIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pair_predecoder.sv
module pair_predecoder
    import pp_pkg::*;
#(
    parameter int FRAME_BITS = 40,
    parameter int SW         = 6,
    parameter int MW         = 7,
    parameter int HIGH_THR   = 20,
    parameter int HIGH_LIMIT = 4,
    parameter int GAP_THR    = 12,
    parameter int GAP_LIMIT  = 7,
    parameter bit BACKWARD   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SW-1:0]         start_state,
    input  logic                  in_valid,
    input  logic [4*MW-1:0]       metrics,
    output logic                  done,
    output logic                  fail,
    output logic [CAUSE_W-1:0]    fail_cause,
    output logic [FRAME_BITS-1:0] word
);
    localparam int PAIRS = FRAME_BITS / 2;
    localparam int IDX_W = $clog2(PAIRS);
    localparam int CNT_W = $clog2(PAIRS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAIRS - 1);
    localparam logic [MW-1:0]    HIGH_T   = MW'(HIGH_THR);
    localparam logic [MW-1:0]    GAP_T    = MW'(GAP_THR);

    typedef struct packed {
        logic                  busy;
        logic [IDX_W-1:0]      idx;
        logic [SW-1:0]         st;
        logic [SW-1:0]         anchor;
        logic [FRAME_BITS-1:0] word;
        logic                  done;
        logic [CAUSE_W-1:0]    cause;
    } regs_t;

    regs_t r_d, r_q;

    pair_t           pick_code;
    logic [MW-1:0]   pick_best, pick_second;
    logic            step, high_over, gap_over;
    logic [SW-1:0]   st_step;
    logic [FRAME_BITS-1:0] word_step;

    pp_pick #(.MW(MW)) u_pick (
        .metrics (metrics),
        .code    (pick_code),
        .best    (pick_best),
        .second  (pick_second)
    );

    assign step = r_q.busy && in_valid && !start;

    pp_tally #(.CW(CNT_W), .HIT_LIMIT(HIGH_LIMIT)) u_high (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .bump  (step && (pick_best > HIGH_T)),
        .over  (high_over)
    );

    pp_tally #(.CW(CNT_W), .HIT_LIMIT(GAP_LIMIT)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .bump  (step && ((pick_second - pick_best) < GAP_T)),
        .over  (gap_over)
    );

    generate
        if (BACKWARD) begin : g_bwd
            assign st_step   = {pick_code, r_q.st[SW-1:2]};
            assign word_step = {pick_code, r_q.word[FRAME_BITS-1:2]};
        end else begin : g_fwd
            assign st_step   = {r_q.st[SW-3:0], pick_code};
            assign word_step = {r_q.word[FRAME_BITS-3:0], pick_code};
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (start) begin
            r_d.busy   = 1'b1;
            r_d.idx    = '0;
            r_d.st     = start_state;
            r_d.anchor = start_state;
        end else if (step) begin
            r_d.st   = st_step;
            r_d.word = word_step;
            if (r_q.idx == LAST_IDX) begin
                r_d.busy              = 1'b0;
                r_d.done              = 1'b1;
                r_d.cause[CAUSE_TAIL] = (st_step != r_q.anchor);
                r_d.cause[CAUSE_HIGH] = high_over;
                r_d.cause[CAUSE_GAP]  = gap_over;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done       = r_q.done;
    assign fail_cause = r_q.cause;
    assign fail       = |r_q.cause;
    assign word       = r_q.word;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
    parameter int MW    = 7,
    parameter int PAIRS = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            in_valid,
    input logic [4*MW-1:0] metrics,
    input logic            done,
    input logic [MW-1:0]   best,
    input logic [MW-1:0]   second
);
    localparam int CW = $clog2(PAIRS + 1);

    logic [CW-1:0] seen;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen  <= '0;
            armed <= 1'b0;
        end else if (start) begin
            seen  <= '0;
            armed <= 1'b1;
        end else if (armed && in_valid) begin
            seen <= seen + 1'b1;
            if (int'(seen) + 1 == PAIRS) armed <= 1'b0;
        end
    end

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(seen) == PAIRS && !armed));

    a_r8_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !start) |=> !done);

    a_r2_best_min: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (best <= metrics[0 +: MW] && best <= metrics[MW +: MW] &&
                      best <= metrics[2*MW +: MW] && best <= metrics[3*MW +: MW]));

    a_r6_second_order: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (second >= best));
endmodule

bind pair_predecoder pp_checker #(.MW(MW), .PAIRS(FRAME_BITS / 2)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .metrics  (metrics),
    .done     (done),
    .best     (pick_best),
    .second   (pick_second)
);

// File: tb/test_pair_predecoder.sv
module test_pair_predecoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  sf = '0, sb = '0;
    logic [27:0] met_f = '0, met_b = '0;
    logic        done_f, fail_f, done_b, fail_b;
    logic [2:0]  cause_f, cause_b;
    logic [39:0] word_f, word_b;

    int compared = 0;
    int mismatched = 0;

    logic [6:0] mt [0:19][0:3];

    typedef struct {
        logic [39:0] word;
        logic [2:0]  cause;
        string       tag;
    } item_t;

    item_t q_f[$];
    item_t q_b[$];

    always #5 clk = ~clk;

    pair_predecoder i_pair_predecoder (
        .clk(clk), .rst_n(rst_n), .start(start), .start_state(sf),
        .in_valid(in_valid), .metrics(met_f), .done(done_f), .fail(fail_f),
        .fail_cause(cause_f), .word(word_f)
    );

    pair_predecoder #(.BACKWARD(1'b1)) i_pair_predecoder_bwd (
        .clk(clk), .rst_n(rst_n), .start(start), .start_state(sb),
        .in_valid(in_valid), .metrics(met_b), .done(done_b), .fail(fail_b),
        .fail_cause(cause_b), .word(word_b)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_item(input string side, input item_t e,
                                input logic [39:0] w, input logic [2:0] c, input logic f);
        check({side, " word ", e.tag}, 64'(w), 64'(e.word));
        check({side, " cause ", e.tag}, 64'(c), 64'(e.cause));
        check({side, " fail R7 ", e.tag}, 64'(f), 64'(|e.cause));
    endtask

    always @(negedge clk) begin
        if (rst_n && done_f) begin
            if (q_f.size() == 0) check("fwd unexpected done R3/R9", 64'd1, 64'd0);
            else compare_item("fwd", q_f.pop_front(), word_f, cause_f, fail_f);
        end
        if (rst_n && done_b) begin
            if (q_b.size() == 0) check("bwd unexpected done R10", 64'd1, 64'd0);
            else compare_item("bwd", q_b.pop_front(), word_b, cause_b, fail_b);
        end
    end

    function automatic logic [27:0] pack(input int k);
        logic [27:0] r;
        for (int c = 0; c < 4; c++) r[c*7 +: 7] = mt[k][c];
        return r;
    endfunction

    task automatic clean(input logic [39:0] f);
        for (int k = 0; k < 20; k++) begin
            for (int c = 0; c < 4; c++)
                mt[k][c] = (2'(c) == f[39-2*k -: 2]) ? 7'd0 : 7'd30;
        end
    endtask

    task automatic expect_frame(input string tag, input logic [5:0] xf, input logic [5:0] xb);
        logic [39:0] w;
        int hi, gp;
        item_t e;
        w = '0; hi = 0; gp = 0;
        for (int k = 0; k < 20; k++) begin
            logic [6:0] b, s;
            logic [1:0] code;
            b = 7'h7f; s = 7'h7f; code = 2'd0;
            for (int c = 0; c < 4; c++) begin
                if (mt[k][c] < b) begin s = b; b = mt[k][c]; code = 2'(c); end
                else if (mt[k][c] < s) s = mt[k][c];
            end
            w[39-2*k -: 2] = code;
            if (b > 7'd20) hi++;
            if ((s - b) < 7'd12) gp++;
        end
        e.word = w;
        e.tag  = tag;
        e.cause = {gp > 7, hi > 4, w[5:0] != xf};
        q_f.push_back(e);
        e.cause[0] = (w[39:34] != xb);
        q_b.push_back(e);
    endtask

    task automatic run(input logic [5:0] xf, input logic [5:0] xb, input bit bubbles);
        @(negedge clk);
        start = 1'b1; sf = xf; sb = xb; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (bubbles && (k % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            met_f = pack(k);
            met_b = pack(19 - k);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [39:0] fa, fb;
        fa = 40'hA53C96E17B;
        fb = 40'h3F0192D4C6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", 64'(done_f), 64'd0);
        check("R1 fail", 64'(fail_f), 64'd0);
        check("R1 cause", 64'(cause_f), 64'd0);
        check("R1 word", 64'(word_f), 64'd0);
        check("R1 bwd word", 64'(word_b), 64'd0);

        // R9 valid while idle is ignored
        clean(40'hFFFFFFFFFF);
        in_valid = 1'b1; met_f = pack(0); met_b = pack(0);
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 idle word", 64'(word_f), 64'd0);

        // R2 R3 R10 clean frame
        clean(fa);
        expect_frame("R3 clean A", fa[5:0], fa[39:34]);
        run(fa[5:0], fa[39:34], 1'b0);

        // R9 gaps inside frame
        clean(fb);
        expect_frame("R9 clean B gaps", fb[5:0], fb[39:34]);
        run(fb[5:0], fb[39:34], 1'b1);

        // R4 wrong starting state
        clean(fa);
        expect_frame("R4 tail mismatch", ~fa[5:0], ~fa[39:34]);
        run(~fa[5:0], ~fa[39:34], 1'b0);

        // R5 boundary: four high sections plus one exactly at threshold
        clean(fb);
        for (int k = 6; k < 10; k++)
            for (int c = 0; c < 4; c++)
                mt[k][c] = (2'(c) == fb[39-2*k -: 2]) ? 7'd25 : 7'd40;
        for (int c = 0; c < 4; c++)
            mt[12][c] = (2'(c) == fb[39-24 -: 2]) ? 7'd20 : 7'd40;
        expect_frame("R5 four high pass", fb[5:0], fb[39:34]);
        run(fb[5:0], fb[39:34], 1'b0);

        // R5 five high sections
        for (int c = 0; c < 4; c++)
            mt[10][c] = (2'(c) == fb[39-20 -: 2]) ? 7'd25 : 7'd40;
        expect_frame("R5 five high fail", fb[5:0], fb[39:34]);
        run(fb[5:0], fb[39:34], 1'b0);

        // R6 boundary: seven narrow sections plus one gap exactly 12
        clean(fa);
        for (int k = 3; k < 10; k++) mt[k][(fa[39-2*k -: 2] == 2'd0) ? 1 : 0] = 7'd11;
        mt[14][(fa[39-28 -: 2] == 2'd0) ? 1 : 0] = 7'd12;
        expect_frame("R6 seven narrow pass", fa[5:0], fa[39:34]);
        run(fa[5:0], fa[39:34], 1'b0);

        // R6 eight narrow sections
        mt[10][(fa[39-20 -: 2] == 2'd0) ? 1 : 0] = 7'd11;
        expect_frame("R6 eight narrow fail", fa[5:0], fa[39:34]);
        run(fa[5:0], fa[39:34], 1'b0);

        // R2 ties resolve to the lower code
        clean(fb);
        mt[8][0] = 7'd0; mt[8][3] = 7'd0;
        mt[9][2] = 7'd0; mt[9][1] = 7'd0;
        expect_frame("R2 tie lower code", fb[5:0], fb[39:34]);
        run(fb[5:0], fb[39:34], 1'b0);

        // R8 restart mid-frame clears counters
        for (int k = 0; k < 20; k++)
            for (int c = 0; c < 4; c++) mt[k][c] = 7'd25 + 7'(c);
        @(negedge clk);
        start = 1'b1; sf = 6'd0; sb = 6'd0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 7; k++) begin
            in_valid = 1'b1; met_f = pack(k); met_b = pack(k);
            @(negedge clk);
        end
        in_valid = 1'b0;
        clean(fa);
        expect_frame("R8 restart", fa[5:0], fa[39:34]);
        run(fa[5:0], fa[39:34], 1'b0);

        // R7 all three causes together
        clean(fb);
        for (int k = 0; k < 5; k++)
            for (int c = 0; c < 4; c++)
                mt[k][c] = (2'(c) == fb[39-2*k -: 2]) ? 7'd25 : 7'd40;
        for (int k = 10; k < 18; k++) mt[k][(fb[39-2*k -: 2] == 2'd0) ? 1 : 0] = 7'd5;
        expect_frame("R7 all causes", ~fb[5:0], ~fb[39:34]);
        run(~fb[5:0], ~fb[39:34], 1'b1);

        repeat (4) @(negedge clk);
        check("R3 fwd results drained", 64'(q_f.size()), 64'd0);
        check("R10 bwd results drained", 64'(q_b.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule